// File: doc/BRIEF.md
# Escaped Byte Stream Command and Memory Write Decoder

This block sits behind a byte-wide receive stream. One reserved escape value, 0xA5, opens an in-band command channel inside the stream. A doubled escape stands for a literal 0xA5 data byte. Any other byte after an escape is a command. Commands set or clear four persistent enable flags (trigger, arm, clock doubling, start). A reset command returns the block to a known state.

All remaining bytes are data. Data bytes pair into 16-bit words, low byte first. The word stream is framed as write transactions, each in this order:

- a channel word;
- a start address;
- an end address;
- payload words, written to incrementing addresses until the end address has been written.

A payload word leaves the block as a one-cycle write strobe with a channel, an address and a data value. The block drops transactions addressed to another board. Transactions carry no length field, and the block checks no addresses.

Back-pressure rule: `in_ready` is tied high. The block takes one byte in every cycle in which `in_valid` is high and never stalls the upstream source. The write port has no ready of its own, so the memory behind it must take one write in any cycle.

Top module: `esc_write_decoder`

## Requirements
- R1: A byte pair 0xA5 0xA5 produces one data byte of value 0xA5. A pair 0xA5 X with X not equal to 0xA5 is a command and produces no data byte.
- R2: For a command byte X, the code X[7:1] selects the flag: 1 = trigger, 2 = arm, 3 = clock doubling, 4 = start. X[0] = 0 sets the flag and X[0] = 1 clears it. The flag output changes on the clock edge that accepts X. Every other command byte except 0x00 leaves all flags unchanged. All flags read 0 after the `rst_n` reset.
- R3: Command 0x00 does three things. It clears all four flags. It discards any held low byte and returns write framing to expect a channel word. It raises `regs_cleared` for exactly one cycle, and in that same cycle all flags read 0.
- R4: A command placed between the two bytes of a word, or between words, does not disturb word assembly or write framing.
- R5: Words are little-endian. `wr_en` is high for the one cycle that follows the clock edge accepting the second byte of a payload word, and in that cycle `wr_data` carries that word.
- R6: A transaction is, in order: a channel word, a start address S, an end address E, and then (E − S + 1) mod 2^ADDR_W payload words written to S, S+1, and so on. The next word after the last payload word is a new channel word.
- R7: `wr_chan` is bits [3:0] of the channel word. Writes are issued only when bits [15:4] of the channel word equal the zero-extended `board_id`. A non-matching transaction is consumed with the same framing but produces no write.
- R8: Address increments wrap modulo 2^ADDR_W.
- R9: `in_ready` is constantly 1, and every byte with `in_valid` high is consumed in its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input ready, constantly 1 |
| in_data | input | 8 | Input byte |
| board_id | input | BOARD_W | This board's address, compared with channel word bits [15:4] |
| wr_en | output | 1 | One-cycle write strobe |
| wr_chan | output | 4 | Target channel within the board |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | 16 | Write data |
| trig_en | output | 1 | Trigger enable flag |
| arm_en | output | 1 | Arm enable flag |
| clkdbl_en | output | 1 | Clock doubling enable flag |
| start_en | output | 1 | Start enable flag |
| regs_cleared | output | 1 | One-cycle pulse after a reset command |

## Verification
Some rules are checked on every cycle by the assertions:

- an escape is resolved by the very next byte;
- flags move only after a command byte;
- the reset pulse lasts one cycle and coincides with cleared flags;
- a write strobe follows only a data byte, never a command.

Other behaviour needs the bench scenarios, because it depends on whole byte sequences:

- the mapping of every command byte value to its flag;
- the write count computed from start and end addresses;
- the address wrap;
- board filtering;
- recovery of framing after a reset command issued in the middle of a transaction.

// File: rtl/esc_dec_pkg.sv
package esc_dec_pkg;
  localparam logic [7:0] ESC_BYTE = 8'hA5;
  localparam int WORD_W = 16;
  localparam int SEL_W = 4;
  localparam int NUM_FLAGS = 4;
  localparam int CODE_W = 7;
  localparam logic [CODE_W-1:0] CODE_RESET = 7'd0;

  typedef enum logic [1:0] {
    PH_CHAN,
    PH_START,
    PH_END,
    PH_DATA
  } wr_phase_t;
endpackage

// File: rtl/esc_unescape.sv
module esc_unescape
  import esc_dec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  output logic       data_stb,
  output logic [7:0] data_byte,
  output logic       cmd_stb,
  output logic [7:0] cmd_byte
);
  logic pending;

  always_comb begin
    data_stb  = 1'b0;
    cmd_stb   = 1'b0;
    data_byte = byte_in;
    cmd_byte  = byte_in;
    if (byte_valid) begin
      if (pending) begin
        if (byte_in == ESC_BYTE) data_stb = 1'b1;
        else cmd_stb = 1'b1;
      end else if (byte_in != ESC_BYTE) begin
        data_stb = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else if (byte_valid) pending <= !pending && (byte_in == ESC_BYTE);
  end

  AST_ESC_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && byte_valid) |=> !pending); // R1
endmodule

// File: rtl/esc_cmd_regs.sv
module esc_cmd_regs
  import esc_dec_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_stb,
  input  logic [7:0]           cmd_byte,
  output logic                 soft_clear,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 rst_pulse
);
  logic [CODE_W-1:0] code;
  assign code = cmd_byte[7:1];
  assign soft_clear = cmd_stb && (code == CODE_RESET) && !cmd_byte[0];

  for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[k] <= 1'b0;
      else if (soft_clear) flags[k] <= 1'b0;
      else if (cmd_stb && code == CODE_W'(k + 1)) flags[k] <= !cmd_byte[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pulse <= 1'b0;
    else rst_pulse <= soft_clear;
  end

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |=> !rst_pulse); // R3
  AST_RST_FLAGS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rst_pulse |-> (flags == '0)); // R3
  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmd_stb) |-> $stable(flags)); // R2
endmodule

// File: rtl/esc_word_framer.sv
module esc_word_framer
  import esc_dec_pkg::*;
#(
  parameter int BOARD_W = 4,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clear,
  input  logic               data_stb,
  input  logic [7:0]         data_byte,
  input  logic               cmd_stb,
  input  logic [BOARD_W-1:0] board_id,
  output logic               wr_en,
  output logic [SEL_W-1:0]   wr_chan,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [WORD_W-1:0]  wr_data
);
  localparam int HI_W = WORD_W - SEL_W;

  wr_phase_t          phase;
  logic               lo_have;
  logic [7:0]         lo_byte;
  logic [WORD_W-1:0]  chan_word;
  logic [ADDR_W-1:0]  cur_addr;
  logic [ADDR_W-1:0]  end_addr;
  logic [WORD_W-1:0]  word;
  logic               board_hit;

  assign word      = {data_byte, lo_byte};
  assign board_hit = (chan_word[WORD_W-1:SEL_W] == HI_W'(board_id));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CHAN;
      lo_have   <= 1'b0;
      lo_byte   <= '0;
      chan_word <= '0;
      cur_addr  <= '0;
      end_addr  <= '0;
      wr_en     <= 1'b0;
      wr_chan   <= '0;
      wr_addr   <= '0;
      wr_data   <= '0;
    end else begin
      wr_en <= 1'b0;
      if (clear) begin
        lo_have <= 1'b0;
        phase   <= PH_CHAN;
      end else if (data_stb) begin
        if (!lo_have) begin
          lo_have <= 1'b1;
          lo_byte <= data_byte;
        end else begin
          lo_have <= 1'b0;
          unique case (phase)
            PH_CHAN: begin
              chan_word <= word;
              phase     <= PH_START;
            end
            PH_START: begin
              cur_addr <= word[ADDR_W-1:0];
              phase    <= PH_END;
            end
            PH_END: begin
              end_addr <= word[ADDR_W-1:0];
              phase    <= PH_DATA;
            end
            PH_DATA: begin
              wr_en    <= board_hit;
              wr_chan  <= chan_word[SEL_W-1:0];
              wr_addr  <= cur_addr;
              wr_data  <= word;
              cur_addr <= cur_addr + 1'b1;
              if (cur_addr == end_addr) phase <= PH_CHAN;
            end
            default: phase <= PH_CHAN;
          endcase
        end
      end
    end
  end

  AST_WR_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(data_stb)); // R5
  AST_CMD_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_stb) |-> !wr_en); // R4
  AST_CLEAR_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clear) |-> !wr_en); // R3
endmodule

// File: rtl/esc_write_decoder.sv
module esc_write_decoder
  import esc_dec_pkg::*;
#(
  parameter int BOARD_W = 4,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [7:0]         in_data,
  input  logic [BOARD_W-1:0] board_id,
  output logic               wr_en,
  output logic [3:0]         wr_chan,
  output logic [ADDR_W-1:0]  wr_addr,
  output logic [15:0]        wr_data,
  output logic               trig_en,
  output logic               arm_en,
  output logic               clkdbl_en,
  output logic               start_en,
  output logic               regs_cleared
);
  logic                 data_stb, cmd_stb, soft_clear;
  logic [7:0]           data_byte, cmd_byte;
  logic [NUM_FLAGS-1:0] flags;

  assign in_ready = 1'b1;

  esc_unescape u_unesc (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_valid(in_valid),
    .byte_in   (in_data),
    .data_stb  (data_stb),
    .data_byte (data_byte),
    .cmd_stb   (cmd_stb),
    .cmd_byte  (cmd_byte)
  );

  esc_cmd_regs u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_stb   (cmd_stb),
    .cmd_byte  (cmd_byte),
    .soft_clear(soft_clear),
    .flags     (flags),
    .rst_pulse (regs_cleared)
  );

  esc_word_framer #(.BOARD_W(BOARD_W), .ADDR_W(ADDR_W)) u_frm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (soft_clear),
    .data_stb (data_stb),
    .data_byte(data_byte),
    .cmd_stb  (cmd_stb),
    .board_id (board_id),
    .wr_en    (wr_en),
    .wr_chan  (wr_chan),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data)
  );

  assign trig_en   = flags[0];
  assign arm_en    = flags[1];
  assign clkdbl_en = flags[2];
  assign start_en  = flags[3];

  AST_DATA_CMD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_cleared && $past(in_valid)) |-> $past(in_data == 8'h00)); // R3
endmodule

// File: tb/esc_write_decoder_tb_top.sv
module esc_write_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic [3:0]  board_id = 4'd7;
  logic        wr_en;
  logic [3:0]  wr_chan;
  logic [15:0] wr_addr;
  logic [15:0] wr_data;
  logic        trig_en, arm_en, clkdbl_en, start_en, regs_cleared;

  int total = 0;
  int bad = 0;
  logic [3:0] exp_flags = 4'h0;

  int          wr_cnt = 0;
  logic [3:0]  log_chan [256];
  logic [15:0] log_addr [256];
  logic [15:0] log_data [256];

  always #5 clk = ~clk;

  esc_write_decoder dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .board_id(board_id), .wr_en(wr_en), .wr_chan(wr_chan),
    .wr_addr(wr_addr), .wr_data(wr_data), .trig_en(trig_en), .arm_en(arm_en),
    .clkdbl_en(clkdbl_en), .start_en(start_en), .regs_cleared(regs_cleared)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      if (wr_cnt < 256) begin
        log_chan[wr_cnt] = wr_chan;
        log_addr[wr_cnt] = wr_addr;
        log_data[wr_cnt] = wr_data;
      end
      wr_cnt = wr_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_data_byte(input logic [7:0] b);
    if (b == 8'hA5) send_byte(8'hA5);
    send_byte(b);
  endtask

  task automatic send_word(input logic [15:0] w, input bit inj);
    send_data_byte(w[7:0]);
    if (inj) begin
      send_byte(8'hA5);
      send_byte(8'h04);
      exp_flags[1] = 1'b1;
    end
    send_data_byte(w[15:8]);
  endtask

  function automatic logic [15:0] pay(input logic [15:0] base, input int i);
    return base + 16'(i * 16'h0103);
  endfunction

  task automatic write_txn(input logic [15:0] chan, input logic [15:0] st,
                           input logic [15:0] en, input logic [15:0] base,
                           input bit inj, input string req);
    int n;
    bit hit;
    n   = int'(16'(en - st)) + 1;
    hit = (chan[15:4] == {8'h00, board_id});
    wr_cnt = 0;
    send_word(chan, inj);
    send_word(st, inj);
    send_word(en, inj);
    for (int i = 0; i < n; i++) begin
      send_word(pay(base, i), inj && (i == 0));
      if (i == n - 1 && hit)
        chk(wr_en === 1'b1 && wr_data === pay(base, i), "R5", int'(wr_data), int'(pay(base, i)));
    end
    @(negedge clk);
    chk(wr_cnt == (hit ? n : 0), req, wr_cnt, hit ? n : 0);
    for (int i = 0; i < wr_cnt && i < 256; i++) begin
      chk(log_chan[i] === chan[3:0], "R7", int'(log_chan[i]), int'(chan[3:0]));
      chk(log_addr[i] === 16'(st + 16'(i)), "R8", int'(log_addr[i]), int'(16'(st + 16'(i))));
      chk(log_data[i] === pay(base, i), "R5", int'(log_data[i]), int'(pay(base, i)));
    end
  endtask

  function automatic logic [3:0] cur_flags();
    return {start_en, clkdbl_en, arm_en, trig_en};
  endfunction

  task automatic cmd_step(input int b);
    logic [6:0] c;
    c = 7'(b >> 1);
    send_byte(8'hA5);
    send_byte(8'(b));
    if (b == 0) exp_flags = 4'h0;
    else if (c >= 7'd1 && c <= 7'd4) exp_flags[c - 7'd1] = ~b[0];
    chk(cur_flags() === exp_flags, "R2", int'(cur_flags()), int'(exp_flags));
    chk(regs_cleared === (b == 0), "R3", int'(regs_cleared), int'(b == 0));
  endtask

  initial begin
    #2_000_000;
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_flags() === 4'h0 && regs_cleared === 1'b0, "R2", int'(cur_flags()), 0);
    chk(wr_en === 1'b0, "R5", int'(wr_en), 0);
    chk(in_ready === 1'b1, "R9", int'(in_ready), 1);

    // R2 R3: sweep every command byte upward, then downward
    for (int b = 0; b < 256; b++) if (b != 8'hA5) cmd_step(b);
    for (int b = 255; b >= 0; b--) if (b != 8'hA5) cmd_step(b);
    for (int b = 2; b < 10; b += 2) cmd_step(b);

    // R6 R7: basic transaction, board 7 dac 2
    write_txn(16'h0072, 16'h0001, 16'h0003, 16'h0005, 1'b0, "R6");
    // R4: arm command inside every header word and the first payload word
    exp_flags = cur_flags();
    write_txn(16'h0070, 16'h0100, 16'h0104, 16'h1234, 1'b1, "R4");
    chk(cur_flags() === exp_flags, "R4", int'(cur_flags()), int'(exp_flags));
    // R1: escaped 0xA5 data bytes
    write_txn(16'h007F, 16'h00A5, 16'h00A6, 16'hA5A5, 1'b0, "R1");
    // R8: address wrap
    write_txn(16'h0071, 16'hFFFE, 16'h0001, 16'h0F00, 1'b0, "R8");
    // R7: other board ignored, then framing continues
    write_txn(16'h0032, 16'h0000, 16'h0002, 16'h4444, 1'b0, "R7");
    write_txn(16'h0070, 16'h0005, 16'h0005, 16'h9999, 1'b0, "R6");
    chk(in_ready === 1'b1, "R9", int'(in_ready), 1);

    // R3: reset in the middle of a transaction restores framing
    send_word(16'h0072, 1'b0);
    send_word(16'h0010, 1'b0);
    send_data_byte(8'h20);
    send_byte(8'hA5);
    send_byte(8'h00);
    chk(regs_cleared === 1'b1 && cur_flags() === 4'h0, "R3", int'(cur_flags()), 0);
    exp_flags = 4'h0;
    write_txn(16'h0073, 16'h0020, 16'h0021, 16'h0ABC, 1'b0, "R3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule